// File: doc/BRIEF.md
# YCbCr 4:2:2 Byte Stream Unpacker

This block takes an 8-bit luma/chroma byte stream in which chroma and luma bytes alternate, with one strobe per accepted byte. It collects each four-byte group into two full pixels, and each pixel carries a luma sample together with the blue-difference and red-difference chroma samples. The two pixels of a group share the one chroma pair sent in that group. The block sits between a video receiver and a pixel pipeline that expects one complete Y/Cb/Cr triple per transfer.

Two run-time controls shape the result. The first picks which chroma byte of a group is blue-difference and which is red-difference. The second replaces every sample with its full-range complement. A line-start input puts the block back at the first byte of a group, so a stream that has lost alignment recovers at the next line boundary. Colour conversion and scaling are done elsewhere.

Top module: `ycc422_unpack`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, `pix_vld_o` is low and all three sample outputs are zero.
- R2: With `swap_chroma_i` low, a group's bytes (in the order they are accepted) are chroma A, luma 0, chroma B, luma 1. Chroma A drives `pix_cb_o` and chroma B drives `pix_cr_o`. Luma 0 belongs to the first pixel and luma 1 to the second.
- R3: With `swap_chroma_i` high when the third byte of a group is accepted, chroma A drives `pix_cr_o` and chroma B drives `pix_cb_o`.
- R4: Both pixels of a group carry the same Cb and Cr values.
- R5: When `invert_i` is high during the cycle a byte is accepted, the sample taken from that byte is 255 minus the received value. When `invert_i` is low, the value passes through unchanged.
- R6: `pix_vld_o` is high for exactly one cycle after the third accepted byte of a group and for exactly one cycle after the fourth. It is never high on three consecutive cycles.
- R7: A cycle with `byte_vld_i` low has no effect on the group phase or on the samples.
- R8: A byte accepted in the same cycle as `line_start_i`, or the first byte accepted after a `line_start_i` pulse that had no byte, is treated as chroma A of a new group.
- R9: Bytes of a group that `line_start_i` cuts short are never used in any later pixel. A group cut off before its third byte produces no pixel.
- R10: While `pix_vld_o` is low, the three sample outputs keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| byte_vld_i | input | 1 | Strobe: `byte_i` is accepted this cycle |
| byte_i | input | 8 | Incoming stream byte |
| line_start_i | input | 1 | Realigns the group phase to its first byte |
| swap_chroma_i | input | 1 | Exchanges the Cb and Cr roles within a group |
| invert_i | input | 1 | Complements each sample taken this cycle |
| pix_vld_o | output | 1 | One-cycle pixel strobe |
| pix_y_o | output | 8 | Luma sample of the pixel |
| pix_cb_o | output | 8 | Blue-difference chroma of the pixel |
| pix_cr_o | output | 8 | Red-difference chroma of the pixel |

## Verification
The bench drives gaps between bytes. A design that advanced its phase on idle cycles would shift every later group, so bytes would land in the wrong sample positions. Line start is tested mid-group both with and without a byte in the same cycle. A design that failed to clear its phase would emit pixels built from bytes of the abandoned group, or would emit an extra pixel. Swap and inversion are toggled inside groups, which exposes a design that samples either control at the wrong byte: such a design would swap chroma of the second pixel apart from the first, or would complement the wrong samples.

// File: rtl/ycc_pkg.sv
package ycc_pkg;

    // Position of the next accepted byte inside a four-byte group.
    typedef enum logic [1:0] {
        PH_CHROMA_A = 2'd0,
        PH_LUMA_0   = 2'd1,
        PH_CHROMA_B = 2'd2,
        PH_LUMA_1   = 2'd3
    } grp_phase_e;

    localparam int unsigned GROUP_BYTES = 4;

endpackage

// File: rtl/ycc_byte_phase.sv
module ycc_byte_phase
    import ycc_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       adv_i,
    input  logic       restart_i,
    output grp_phase_e phase_o
);

    typedef struct packed {
        logic [1:0] ph;
    } ph_st_t;

    ph_st_t st_d, st_q;
    logic [1:0] cur_ph;

    always_comb begin
        // A restart makes the byte in this cycle (if any) the first of a group.
        cur_ph = restart_i ? 2'(PH_CHROMA_A) : st_q.ph;
        st_d   = st_q;
        st_d.ph = adv_i ? cur_ph + 2'd1 : cur_ph;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign phase_o = grp_phase_e'(cur_ph);

endmodule

// File: rtl/ycc_sample_cond.sv
module ycc_sample_cond #(
    parameter int unsigned SAMPLE_W = 8
) (
    input  logic [SAMPLE_W-1:0] raw_i,
    input  logic                invert_i,
    output logic [SAMPLE_W-1:0] smp_o
);

    localparam logic [SAMPLE_W-1:0] FULL_SCALE = '1;

    always_comb begin
        smp_o = invert_i ? (FULL_SCALE - raw_i) : raw_i;
    end

endmodule

// File: rtl/ycc422_unpack.sv
module ycc422_unpack
    import ycc_pkg::*;
#(
    parameter int unsigned SAMPLE_W = 8
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                byte_vld_i,
    input  logic [SAMPLE_W-1:0] byte_i,
    input  logic                line_start_i,
    input  logic                swap_chroma_i,
    input  logic                invert_i,
    output logic                pix_vld_o,
    output logic [SAMPLE_W-1:0] pix_y_o,
    output logic [SAMPLE_W-1:0] pix_cb_o,
    output logic [SAMPLE_W-1:0] pix_cr_o
);

    typedef struct packed {
        logic                vld;
        logic [SAMPLE_W-1:0] y;
        logic [SAMPLE_W-1:0] cb;
        logic [SAMPLE_W-1:0] cr;
        logic [SAMPLE_W-1:0] chroma_a;
        logic [SAMPLE_W-1:0] luma_0;
    } unp_st_t;

    unp_st_t             st_d, st_q;
    grp_phase_e          phase;
    logic [SAMPLE_W-1:0] smp;

    ycc_byte_phase u_phase (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .adv_i     (byte_vld_i),
        .restart_i (line_start_i),
        .phase_o   (phase)
    );

    ycc_sample_cond #(
        .SAMPLE_W (SAMPLE_W)
    ) u_cond (
        .raw_i    (byte_i),
        .invert_i (invert_i),
        .smp_o    (smp)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        if (byte_vld_i) begin
            unique case (phase)
                PH_CHROMA_A: st_d.chroma_a = smp;
                PH_LUMA_0:   st_d.luma_0   = smp;
                PH_CHROMA_B: begin
                    // First pixel: the chroma pair is resolved now and held in the
                    // output registers for the second pixel.
                    st_d.vld = 1'b1;
                    st_d.y   = st_q.luma_0;
                    st_d.cb  = swap_chroma_i ? smp : st_q.chroma_a;
                    st_d.cr  = swap_chroma_i ? st_q.chroma_a : smp;
                end
                PH_LUMA_1: begin
                    st_d.vld = 1'b1;
                    st_d.y   = smp;
                end
                default: st_d.vld = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pix_vld_o = st_q.vld;
    assign pix_y_o   = st_q.y;
    assign pix_cb_o  = st_q.cb;
    assign pix_cr_o  = st_q.cr;

endmodule

// File: rtl/ycc422_unpack_chk.sv
module ycc422_unpack_chk #(
    parameter int unsigned SAMPLE_W = 8
) (
    input logic                clk_i,
    input logic                rst_ni,
    input logic                byte_vld_i,
    input logic                line_start_i,
    input logic                pix_vld_o,
    input logic [SAMPLE_W-1:0] pix_y_o,
    input logic [SAMPLE_W-1:0] pix_cb_o,
    input logic [SAMPLE_W-1:0] pix_cr_o
);

    logic armed_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            armed_q <= 1'b0;
        end else begin
            armed_q <= 1'b1;
        end
    end

    // R6: a pixel strobe always follows an accepted byte
    a_r6_vld_after_byte: assert property (@(posedge clk_i) disable iff (!(rst_ni && armed_q))
        pix_vld_o |-> $past(byte_vld_i));

    // R6: at most two strobes in a row
    a_r6_no_third_pulse: assert property (@(posedge clk_i) disable iff (!(rst_ni && armed_q))
        (pix_vld_o && $past(pix_vld_o)) |=> !pix_vld_o);

    // R8: a byte taken with line start is chroma A, which produces no pixel
    a_r8_start_byte_silent: assert property (@(posedge clk_i) disable iff (!(rst_ni && armed_q))
        (line_start_i && byte_vld_i) |=> !pix_vld_o);

    // R4: back-to-back pixels share one chroma pair
    a_r4_shared_chroma: assert property (@(posedge clk_i) disable iff (!(rst_ni && armed_q))
        (pix_vld_o && $past(pix_vld_o)) |-> ($stable(pix_cb_o) && $stable(pix_cr_o)));

    // R10: samples hold while no pixel is presented
    a_r10_hold_idle: assert property (@(posedge clk_i) disable iff (!(rst_ni && armed_q))
        !pix_vld_o |-> ($stable(pix_y_o) && $stable(pix_cb_o) && $stable(pix_cr_o)));

endmodule

bind ycc422_unpack ycc422_unpack_chk #(
    .SAMPLE_W (SAMPLE_W)
) u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .byte_vld_i   (byte_vld_i),
    .line_start_i (line_start_i),
    .pix_vld_o    (pix_vld_o),
    .pix_y_o      (pix_y_o),
    .pix_cb_o     (pix_cb_o),
    .pix_cr_o     (pix_cr_o)
);

// File: tb/ycc422_unpack_tb_top.sv
module ycc422_unpack_tb_top;

    logic       clk_i = 1'b0;
    logic       rst_ni = 1'b0;
    logic       byte_vld_i = 1'b0;
    logic [7:0] byte_i = '0;
    logic       line_start_i = 1'b0;
    logic       swap_chroma_i = 1'b0;
    logic       invert_i = 1'b0;
    logic       pix_vld_o;
    logic [7:0] pix_y_o, pix_cb_o, pix_cr_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk_i = ~clk_i;

    ycc422_unpack dut_i (
        .clk_i         (clk_i),
        .rst_ni        (rst_ni),
        .byte_vld_i    (byte_vld_i),
        .byte_i        (byte_i),
        .line_start_i  (line_start_i),
        .swap_chroma_i (swap_chroma_i),
        .invert_i      (invert_i),
        .pix_vld_o     (pix_vld_o),
        .pix_y_o       (pix_y_o),
        .pix_cb_o      (pix_cb_o),
        .pix_cr_o      (pix_cr_o)
    );

    // ---------------- behavioural reference ----------------
    int   m_cnt;
    int   m_grp [4];
    int   m_cb, m_cr;
    bit   exp_vld = 1'b0;
    int   exp_y = 0, exp_cb = 0, exp_cr = 0;

    always @(posedge clk_i) begin
        int v;
        if (!rst_ni) begin
            m_cnt = 0;
            exp_vld <= 1'b0;
            exp_y <= 0; exp_cb <= 0; exp_cr <= 0;
        end else begin
            exp_vld <= 1'b0;
            if (line_start_i) m_cnt = 0;
            if (byte_vld_i) begin
                v = invert_i ? 255 - int'(byte_i) : int'(byte_i);
                m_grp[m_cnt] = v;
                m_cnt = m_cnt + 1;
                if (m_cnt == 3) begin
                    m_cb = swap_chroma_i ? v : m_grp[0];
                    m_cr = swap_chroma_i ? m_grp[0] : v;
                    exp_vld <= 1'b1;
                    exp_y <= m_grp[1]; exp_cb <= m_cb; exp_cr <= m_cr;
                end else if (m_cnt == 4) begin
                    exp_vld <= 1'b1;
                    exp_y <= v; exp_cb <= m_cb; exp_cr <= m_cr;
                    m_cnt = 0;
                end
            end
        end
    end

    // ---------------- per-cycle comparison and capture ----------------
    int got_y [$];
    int got_cb [$];
    int got_cr [$];

    always @(negedge clk_i) begin
        if (rst_ni && !done) begin
            checks++;
            if (pix_vld_o !== exp_vld) begin
                errors++;
                $display("FAIL R6 pixel strobe actual %0b expected %0b", pix_vld_o, exp_vld);
            end else if (int'(pix_y_o) != exp_y || int'(pix_cb_o) != exp_cb || int'(pix_cr_o) != exp_cr) begin
                errors++;
                if (exp_vld)
                    $display("FAIL R2 samples actual %h/%h/%h expected %h/%h/%h",
                             pix_y_o, pix_cb_o, pix_cr_o, exp_y[7:0], exp_cb[7:0], exp_cr[7:0]);
                else
                    $display("FAIL R10 held samples actual %h/%h/%h expected %h/%h/%h",
                             pix_y_o, pix_cb_o, pix_cr_o, exp_y[7:0], exp_cb[7:0], exp_cr[7:0]);
            end
            if (pix_vld_o) begin
                got_y.push_back(int'(pix_y_o));
                got_cb.push_back(int'(pix_cb_o));
                got_cr.push_back(int'(pix_cr_o));
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic drive(input bit vld, input logic [7:0] b, input bit ls);
        byte_vld_i   = vld;
        byte_i       = b;
        line_start_i = ls;
        @(negedge clk_i);
        byte_vld_i   = 1'b0;
        line_start_i = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk_i);
    endtask

    task automatic check_count(input string req, input int n);
        checks++;
        if (got_y.size() != n) begin
            errors++;
            $display("FAIL %s pixel count actual %0d expected %0d", req, got_y.size(), n);
        end
    endtask

    task automatic check_pix(input string req, input int y, input int cb, input int cr);
        int ay, acb, acr;
        checks++;
        if (got_y.size() == 0) begin
            errors++;
            $display("FAIL %s missing pixel actual none expected %h/%h/%h", req, y, cb, cr);
        end else begin
            ay = got_y.pop_front(); acb = got_cb.pop_front(); acr = got_cr.pop_front();
            if (ay != y || acb != cb || acr != cr) begin
                errors++;
                $display("FAIL %s pixel actual %h/%h/%h expected %h/%h/%h", req, ay, acb, acr, y, cb, cr);
            end
        end
    endtask

    task automatic flush();
        got_y.delete(); got_cb.delete(); got_cr.delete();
    endtask

    task automatic report();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk_i);
        errors++;
        $display("FAIL watchdog expired actual running expected finished");
        report();
    end

    // ---------------- stimulus ----------------
    initial begin
        idle(1);
        // R1: reset state
        checks++;
        if (pix_vld_o !== 1'b0 || pix_y_o !== 8'h00 || pix_cb_o !== 8'h00 || pix_cr_o !== 8'h00) begin
            errors++;
            $display("FAIL R1 reset outputs actual %b %h/%h/%h expected 0 00/00/00",
                     pix_vld_o, pix_y_o, pix_cb_o, pix_cr_o);
        end
        idle(2);
        rst_ni = 1'b1;
        idle(1);
        checks++;
        if (pix_vld_o !== 1'b0 || pix_y_o !== 8'h00) begin
            errors++;
            $display("FAIL R1 after release actual %b %h expected 0 00", pix_vld_o, pix_y_o);
        end

        // R2, R4, R6: plain order
        drive(1, 8'h40, 1); drive(1, 8'h11, 0); drive(1, 8'hC0, 0); drive(1, 8'h22, 0);
        idle(3);
        check_count("R6", 2);
        check_pix("R2", 8'h11, 8'h40, 8'hC0);
        check_pix("R4", 8'h22, 8'h40, 8'hC0);

        // R3: swapped chroma order
        swap_chroma_i = 1'b1;
        drive(1, 8'h40, 0); drive(1, 8'h11, 0); drive(1, 8'hC0, 0); drive(1, 8'h22, 0);
        idle(3);
        swap_chroma_i = 1'b0;
        check_count("R3", 2);
        check_pix("R3", 8'h11, 8'hC0, 8'h40);
        check_pix("R3", 8'h22, 8'hC0, 8'h40);

        // R5: inversion
        invert_i = 1'b1;
        drive(1, 8'h00, 0); drive(1, 8'h10, 0); drive(1, 8'hFF, 0); drive(1, 8'h7F, 0);
        idle(3);
        invert_i = 1'b0;
        check_pix("R5", 8'hEF, 8'hFF, 8'h00);
        check_pix("R5", 8'h80, 8'hFF, 8'h00);

        // R7: gaps between bytes do not advance the phase
        drive(1, 8'h21, 0); idle(2); drive(1, 8'h31, 0); idle(3);
        drive(1, 8'h41, 0); idle(1); drive(1, 8'h51, 0);
        idle(3);
        check_count("R7", 2);
        check_pix("R7", 8'h31, 8'h21, 8'h41);
        check_pix("R7", 8'h51, 8'h21, 8'h41);

        // R8/R9: line start with a byte cuts a two-byte partial group
        drive(1, 8'h01, 0); drive(1, 8'h02, 0);
        drive(1, 8'h50, 1); drive(1, 8'h33, 0); drive(1, 8'h60, 0); drive(1, 8'h44, 0);
        idle(3);
        check_count("R9", 2);
        check_pix("R8", 8'h33, 8'h50, 8'h60);
        check_pix("R9", 8'h44, 8'h50, 8'h60);

        // R8: line start pulse without a byte
        drive(1, 8'h05, 0);
        drive(0, 8'hAA, 1);
        idle(1);
        drive(1, 8'h70, 0); drive(1, 8'h12, 0); drive(1, 8'h80, 0); drive(1, 8'h13, 0);
        idle(3);
        check_count("R8", 2);
        check_pix("R8", 8'h12, 8'h70, 8'h80);
        check_pix("R8", 8'h13, 8'h70, 8'h80);

        // R9: group cut after its third byte yields only its first pixel
        drive(1, 8'h40, 0); drive(1, 8'h11, 0); drive(1, 8'hC0, 0);
        drive(1, 8'h50, 1); drive(1, 8'h33, 0); drive(1, 8'h60, 0); drive(1, 8'h44, 0);
        idle(3);
        check_count("R9", 3);
        check_pix("R9", 8'h11, 8'h40, 8'hC0);
        check_pix("R9", 8'h33, 8'h50, 8'h60);
        check_pix("R9", 8'h44, 8'h50, 8'h60);

        // R10 and all others: random stream against the reference every cycle
        for (int i = 0; i < 3000; i++) begin
            swap_chroma_i = ($urandom_range(0, 3) == 0);
            invert_i      = ($urandom_range(0, 3) == 0);
            drive($urandom_range(0, 2) != 0, 8'($urandom_range(0, 255)), $urandom_range(0, 29) == 0);
        end
        idle(4);
        flush();
        report();
    end

endmodule